// File: doc/BRIEF.md
# Integer Execute Stage

This block is the execute stage of a simple 32-bit load/store processor. Each cycle it takes a 32-bit instruction word and the two source operand values, which an earlier stage has already read from the register file. It decodes the instruction fields, performs the operation and registers three things: the result, the index of the destination register and a write-enable. All of these appear one clock after the inputs.

Two instruction layouts are recognised. The register layout carries an operation code, three register indices, a shift amount and a function code. The immediate layout carries an operation code, two register indices and a 16-bit constant. The supported operations are:

- add, subtract, AND, OR and NOR on two registers;
- logical shifts left and right by a constant amount;
- add, AND and OR with an immediate constant.

Any encoding outside this set clears the write-enable and raises an illegal flag, so the write-back stage discards the result.

Top module: `xu_exec_stage`

## Requirements
- R1: While rst_n is low, all outputs are zero. Outputs stay zero until the first rising clock edge after release.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.
- R3: Field positions are op=[31:26], rs=[25:21], rt=[20:16], rd=[15:11], shamt=[10:6], funct=[5:0] and imm=[15:0]. When op=0 and funct=32, the result is src_a+src_b. When op=0 and funct=34, the result is src_a-src_b. Both wrap modulo 2^32 and never trap. Register-layout operations write to rd with wr_en=1.
- R4: With op=0, funct=36 gives src_a AND src_b, funct=37 gives src_a OR src_b, and funct=39 gives NOT(src_a OR src_b). NOR with src_b=0 therefore returns the bitwise inverse of src_a.
- R5: With op=0, funct=0 shifts src_b left by shamt and funct=2 shifts src_b right by shamt. Both fill vacated bits with zeros and ignore src_a. A shift with shamt=0 returns src_b unchanged.
- R6: op=8 adds the sign-extended imm to src_a. The result is written to rt, and src_b is ignored.
- R7: op=12 returns src_a AND the zero-extended imm. op=13 returns src_a OR the zero-extended imm. Both write to rt.
- R8: The following encodings are illegal:
  - any op other than 0, 8, 12 and 13;
  - op=0 with a funct outside {0,2,32,34,36,37,39};
  - a shift with a nonzero rs field;
  - a non-shift register operation with a nonzero shamt field.

  An illegal encoding gives illegal=1, wr_en=0, result=0 and dest=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 32 | Value of the first source register (rs) |
| src_b_i | input | 32 | Value of the second source register (rt) |
| result_o | output | 32 | Registered result |
| dest_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered write-enable |
| illegal_o | output | 1 | Registered illegal-encoding flag |

## Verification
Two functions can land on the same clock edge: reset, and the capture of a legal instruction. The bench holds rst_n low while a valid add is presented across a rising edge. It then checks that all outputs stay zero. It also checks that the add appears exactly one edge after release. A second overlap occurs inside the decode itself. A legal funct paired with a nonzero shamt, or a shift with a nonzero rs field, must be judged illegal rather than executed. Both cases are checked at the output ports.

// File: rtl/xu_pkg.sv
package xu_pkg;
    localparam int XLEN     = 32;
    localparam int RIDX_W   = 5;
    localparam int OPC_W    = 6;
    localparam int FN_W     = 6;
    localparam int IMM_W    = 16;
    localparam int SHAMT_W  = $clog2(XLEN);

    // field positions (low bit of each field)
    localparam int OPC_LSB   = XLEN - OPC_W;
    localparam int RS_LSB    = OPC_LSB - RIDX_W;
    localparam int RT_LSB    = RS_LSB - RIDX_W;
    localparam int RD_LSB    = RT_LSB - RIDX_W;
    localparam int SHAMT_LSB = RD_LSB - SHAMT_W;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
    localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;

    localparam logic [FN_W-1:0] FN_SLL = 6'd0;
    localparam logic [FN_W-1:0] FN_SRL = 6'd2;
    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB = 6'd34;
    localparam logic [FN_W-1:0] FN_AND = 6'd36;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_NOR = 6'd39;

    typedef enum logic [2:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_NOR, K_SLL, K_SRL
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic                use_imm;
        logic [XLEN-1:0]     imm;
        logic [RIDX_W-1:0]   dest;
        logic [SHAMT_W-1:0]  shamt;
        logic                legal;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0]   result;
        logic [RIDX_W-1:0] dest;
        logic              wr_en;
        logic              illegal;
    } stage_t;
endpackage

// File: rtl/xu_decode.sv
module xu_decode
    import xu_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output dec_t            dec_o
);
    logic [OPC_W-1:0]   opc;
    logic [RIDX_W-1:0]  rs, rt, rd;
    logic [SHAMT_W-1:0] shamt;
    logic [FN_W-1:0]    fn;
    logic [IMM_W-1:0]   imm16;

    assign opc   = instr_i[OPC_LSB +: OPC_W];
    assign rs    = instr_i[RS_LSB +: RIDX_W];
    assign rt    = instr_i[RT_LSB +: RIDX_W];
    assign rd    = instr_i[RD_LSB +: RIDX_W];
    assign shamt = instr_i[SHAMT_LSB +: SHAMT_W];
    assign fn    = instr_i[FN_W-1:0];
    assign imm16 = instr_i[IMM_W-1:0];

    always_comb begin
        dec_o         = '0;
        dec_o.kind    = K_ADD;
        dec_o.shamt   = shamt;
        unique case (opc)
            OPC_REG: begin
                dec_o.dest  = rd;
                dec_o.legal = 1'b1;
                unique case (fn)
                    FN_ADD: dec_o.kind = K_ADD;
                    FN_SUB: dec_o.kind = K_SUB;
                    FN_AND: dec_o.kind = K_AND;
                    FN_OR:  dec_o.kind = K_OR;
                    FN_NOR: dec_o.kind = K_NOR;
                    FN_SLL: dec_o.kind = K_SLL;
                    FN_SRL: dec_o.kind = K_SRL;
                    default: dec_o.legal = 1'b0;
                endcase
                // shifts take their amount from shamt and have no rs operand;
                // every other register operation must leave shamt at zero
                if (fn == FN_SLL || fn == FN_SRL) begin
                    if (rs != '0) dec_o.legal = 1'b0;
                end else if (shamt != '0) begin
                    dec_o.legal = 1'b0;
                end
            end
            OPC_ADDI: begin
                dec_o.kind    = K_ADD;
                dec_o.use_imm = 1'b1;
                dec_o.imm     = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
                dec_o.dest    = rt;
                dec_o.legal   = 1'b1;
            end
            OPC_ANDI: begin
                dec_o.kind    = K_AND;
                dec_o.use_imm = 1'b1;
                dec_o.imm     = {{(XLEN-IMM_W){1'b0}}, imm16};
                dec_o.dest    = rt;
                dec_o.legal   = 1'b1;
            end
            OPC_ORI: begin
                dec_o.kind    = K_OR;
                dec_o.use_imm = 1'b1;
                dec_o.imm     = {{(XLEN-IMM_W){1'b0}}, imm16};
                dec_o.dest    = rt;
                dec_o.legal   = 1'b1;
            end
            default: dec_o.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/xu_shift.sv
module xu_shift
    import xu_pkg::*;
(
    input  logic [XLEN-1:0]    din_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic               left_i,
    output logic [XLEN-1:0]    dout_o
);
    // Right-shifting barrel; a left shift mirrors the word on entry and exit.
    logic [XLEN-1:0] stg [SHAMT_W+1];
    logic [XLEN-1:0] din_rev, out_rev;

    always_comb begin
        for (int i = 0; i < XLEN; i++) din_rev[i] = din_i[XLEN-1-i];
    end

    assign stg[0] = left_i ? din_rev : din_i;

    for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
        assign stg[s+1] = amt_i[s] ? (stg[s] >> (1 << s)) : stg[s];
    end

    always_comb begin
        for (int i = 0; i < XLEN; i++) out_rev[i] = stg[SHAMT_W][XLEN-1-i];
    end

    assign dout_o = left_i ? out_rev : stg[SHAMT_W];
endmodule

// File: rtl/xu_alu.sv
module xu_alu
    import xu_pkg::*;
(
    input  dec_t            dec_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] y_o
);
    logic [XLEN-1:0] opnd_b, sh_out;

    assign opnd_b = dec_i.use_imm ? dec_i.imm : b_i;

    xu_shift u_shift (
        .din_i  (b_i),
        .amt_i  (dec_i.shamt),
        .left_i (dec_i.kind == K_SLL),
        .dout_o (sh_out)
    );

    always_comb begin
        unique case (dec_i.kind)
            K_ADD:   y_o = a_i + opnd_b;
            K_SUB:   y_o = a_i - opnd_b;
            K_AND:   y_o = a_i & opnd_b;
            K_OR:    y_o = a_i | opnd_b;
            K_NOR:   y_o = ~(a_i | opnd_b);
            K_SLL,
            K_SRL:   y_o = sh_out;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/xu_exec_stage.sv
module xu_exec_stage
    import xu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   instr_i,
    input  logic [XLEN-1:0]   src_a_i,
    input  logic [XLEN-1:0]   src_b_i,
    output logic [XLEN-1:0]   result_o,
    output logic [RIDX_W-1:0] dest_o,
    output logic              wr_en_o,
    output logic              illegal_o
);
    dec_t            dec;
    logic [XLEN-1:0] alu_y;
    stage_t          st_d, st_q;

    xu_decode u_dec (.instr_i(instr_i), .dec_o(dec));
    xu_alu    u_alu (.dec_i(dec), .a_i(src_a_i), .b_i(src_b_i), .y_o(alu_y));

    always_comb begin
        st_d = '0;
        if (dec.legal) begin
            st_d.result = alu_y;
            st_d.dest   = dec.dest;
            st_d.wr_en  = 1'b1;
        end else begin
            st_d.illegal = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o  = st_q.result;
    assign dest_o    = st_q.dest;
    assign wr_en_o   = st_q.wr_en;
    assign illegal_o = st_q.illegal;

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && result_o == '0 && dest_o == '0));

    // R4
    nor_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(instr_i[31:26]) == OPC_REG && $past(instr_i[5:0]) == FN_NOR)
        |-> ((result_o & $past(src_a_i)) == '0));

    // R5
    srl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(instr_i[31:26]) == OPC_REG && $past(instr_i[5:0]) == FN_SRL
         && $past(instr_i[10:6]) != '0) |-> !result_o[XLEN-1]);

    // R7
    ori_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(instr_i[31:26]) == OPC_ORI)
        |-> (result_o[XLEN-1:IMM_W] == $past(src_a_i[XLEN-1:IMM_W])));

    // R6
    addi_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(instr_i[31:26]) == OPC_ADDI) |-> dest_o == $past(instr_i[20:16]));
endmodule

// File: tb/sim_xu_exec_stage.sv
module sim_xu_exec_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0, a = '0, b = '0;
    logic [31:0] result;
    logic [4:0]  dest;
    logic        wr_en, illegal;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    xu_exec_stage u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .src_a_i(a), .src_b_i(b),
        .result_o(result), .dest_o(dest), .wr_en_o(wr_en), .illegal_o(illegal)
    );

    // {instr, a, b, exp_result, exp_dest, exp_we, exp_ill}
    localparam int NV = 16;
    localparam logic [134:0] VEC [NV] = '{
        {32'h02324020, 32'd5,        32'd7,        32'd12,       5'd8, 1'b1, 1'b0}, // R3 add
        {32'h02324020, 32'hFFFFFFFF, 32'd2,        32'd1,        5'd8, 1'b1, 1'b0}, // R3 wrap
        {32'h02324022, 32'd3,        32'd5,        32'hFFFFFFFE, 5'd8, 1'b1, 1'b0}, // R3 sub
        {32'h02324024, 32'h00003C00, 32'h00000DC0, 32'h00000C00, 5'd8, 1'b1, 1'b0}, // R4 and
        {32'h02324025, 32'h00003C00, 32'h00000DC0, 32'h00003DC0, 5'd8, 1'b1, 1'b0}, // R4 or
        {32'h02324027, 32'h00003C00, 32'h0,        32'hFFFFC3FF, 5'd8, 1'b1, 1'b0}, // R4 nor
        {32'h00124100, 32'hFFFFFFFF, 32'h80000001, 32'h00000010, 5'd8, 1'b1, 1'b0}, // R5 sll 4
        {32'h001247C2, 32'hFFFFFFFF, 32'h80000000, 32'h00000001, 5'd8, 1'b1, 1'b0}, // R5 srl 31
        {32'h00124002, 32'h0,        32'hDEADBEEF, 32'hDEADBEEF, 5'd8, 1'b1, 1'b0}, // R5 srl 0
        {32'h2229FFFF, 32'd10,       32'hFFFFFFFF, 32'd9,        5'd9, 1'b1, 1'b0}, // R6 -1
        {32'h22297FFF, 32'd1,        32'h0,        32'h00008000, 5'd9, 1'b1, 1'b0}, // R6 max
        {32'h3229FFFF, 32'hFFFFFFFF, 32'h0,        32'h0000FFFF, 5'd9, 1'b1, 1'b0}, // R7 andi
        {32'h36298000, 32'h12340000, 32'h0,        32'h12348000, 5'd9, 1'b1, 1'b0}, // R7 ori
        {32'hFC000000, 32'd1,        32'd2,        32'h0,        5'd0, 1'b0, 1'b1}, // R8 op
        {32'h02324021, 32'd1,        32'd2,        32'h0,        5'd0, 1'b0, 1'b1}, // R8 funct
        {32'h02324060, 32'd1,        32'd2,        32'h0,        5'd0, 1'b0, 1'b1}  // R8 shamt
    };

    task automatic check(input string tag, input logic [31:0] er, input logic [4:0] ed,
                         input logic ew, input logic ei);
        n_chk++;
        if (result !== er || dest !== ed || wr_en !== ew || illegal !== ei) begin
            n_fail++;
            $display("FAIL %s: got res=%h dest=%0d we=%b ill=%b exp res=%h dest=%0d we=%b ill=%b",
                     tag, result, dest, wr_en, illegal, er, ed, ew, ei);
        end
    endtask

    task automatic run(input logic [31:0] i, input logic [31:0] va, input logic [31:0] vb);
        @(negedge clk);
        instr = i; a = va; b = vb;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 reset", 32'h0, 5'd0, 1'b0, 1'b0);
        // R1 reset coinciding with a valid add across an edge
        instr = 32'h02324020; a = 32'd40; b = 32'd2;
        @(negedge clk);
        check("R1 reset+instr", 32'h0, 5'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 first edge after release", 32'd42, 5'd8, 1'b1, 1'b0);

        for (int k = 0; k < NV; k++) begin
            run(VEC[k][134:103], VEC[k][102:71], VEC[k][70:39]);
            check($sformatf("R3-R8 vector %0d", k), VEC[k][38:7], VEC[k][6:2], VEC[k][1], VEC[k][0]);
        end

        // R5 shift with nonzero rs is illegal
        run(32'h00324100, 32'd0, 32'd1);
        check("R5 shift rs!=0", 32'h0, 5'd0, 1'b0, 1'b1);
        // R4 nor with zero src_b inverts src_a
        run(32'h02324027, 32'hA5A50F0F, 32'h0);
        check("R4 nor invert", 32'h5A5AF0F0, 5'd8, 1'b1, 1'b0);

        // R2 back-to-back: outputs move exactly one edge after inputs
        @(negedge clk); instr = 32'h02324022; a = 32'd100; b = 32'd1;
        @(posedge clk); #1;
        check("R2 latency", 32'd99, 5'd8, 1'b1, 1'b0);
        instr = 32'h2229FFFE; a = 32'd100;
        @(posedge clk); #1;
        check("R2 next", 32'd98, 5'd9, 1'b1, 1'b0);

        // randomized operands
        for (int k = 0; k < 60; k++) begin
            logic [31:0] ra, rb, ins, exp;
            logic [15:0] im;
            logic [4:0]  ed;
            ra = $urandom; rb = $urandom; im = 16'($urandom);
            case (k % 4)
                0: begin ins = 32'h02324020; exp = ra + rb; ed = 5'd8; end            // R3
                1: begin ins = 32'h02324022; exp = ra - rb; ed = 5'd8; end            // R3
                2: begin ins = {16'h2229, im}; exp = ra + {{16{im[15]}}, im}; ed = 5'd9; end // R6
                default: begin ins = {16'h3629, im}; exp = ra | {16'h0, im}; ed = 5'd9; end  // R7
            endcase
            run(ins, ra, rb);
            check("R3/R6/R7 random", exp, ed, 1'b1, 1'b0);
        end

        // R1 mid-run reset clears outputs
        @(negedge clk); rst_n = 1'b0; #1;
        check("R1 async reset", 32'h0, 5'd0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule